// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block produces the AES-128 key schedule one round key per cycle, in lock step with an iterative encryption datapath. A load strobe captures a 128-bit cipher key and presents it as round key 0. Each advance strobe after that derives the following round key from the one currently held, so only four 32-bit words of the schedule are ever stored rather than the whole expanded table.

The next key is computed combinationally from the held key. The last word is rotated by one byte and each of its bytes goes through an S-box that this block computes for itself. The result is combined with a round constant. The new words then chain through the old ones by XOR. The round index beside the key tells the cipher core which round the key belongs to. Once round 10 is reached, further advances are ignored until the next load.

Top module: `aes_rkey_gen`

## Requirements
- R1: While reset is asserted, and after its release with no strobe, `round_o` is 0 and `rkey_o` is all zeros.
- R2: One cycle after `load_i` is high, `round_o` is 0 and `rkey_o` equals the `key_i` value sampled with the load.
- R3: One cycle after `adv_i` is high with `load_i` low and `round_o` below 10, `round_o` has increased by exactly one.
- R4: With the key split into words W0..W3, W0 being bits 127:96, each advance gives N0 = W0 ^ T, N1 = W1 ^ N0, N2 = W2 ^ N1 and N3 = W3 ^ N2. T is the AES S-box applied to each byte of W3 rotated left by one byte, XORed with the round constant in the top byte.
- R5: The round constant used to enter round n (1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in that order; for key 000102030405060708090a0b0c0d0e0f, round key 1 is d6aa74fdd2af72fadaa678f1d6ab76fe.
- R6: An advance while `round_o` is 10 leaves `round_o` and `rkey_o` unchanged.
- R7: When `load_i` and `adv_i` are high in the same cycle, the load takes effect and the advance is dropped.
- R8: In a cycle with neither strobe, `round_o` and `rkey_o` hold their values.
- R9: For key 000102030405060708090a0b0c0d0e0f, round key 10 is 13111d7fe3944a17f307a78b4d2b30c5; for key 2b7e151628aed2a6abf7158809cf4f3c it is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R10: `round_o` never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `key_i` as round key 0 |
| adv_i | input | 1 | Step to the next round key |
| key_i | input | 128 | Cipher key |
| rkey_o | output | 128 | Current round key, word 0 in bits 127:96 |
| round_o | output | 4 | Round index of `rkey_o` (0..10) |

## Verification
The bench builds the block with its default parameters: 32-bit words, four words per key and ten rounds. These defaults take the round index to its limit of 10, where ignored advances, a simultaneous load and advance, and idle holds can all be exercised. Two cipher keys are walked through every round. The bench's reference derives the S-box by an inverse search in GF(2^8) rather than the RTL's exponent chain, and the published round keys pin both the S-box and the round constants.

// File: rtl/aes_ks_pkg.sv
`timescale 1ns/1ps
package aes_ks_pkg;
   localparam int BYTE_W = 8;

   function automatic logic [7:0] gf_x2(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (8'h1b & {8{a[7]}});
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_x2(sh);
      end
      return acc;
   endfunction

   // multiplicative inverse as x^254, then the affine map
   function automatic logic [7:0] sbox_calc(input logic [7:0] x);
      logic [7:0] r;
      logic [7:0] base;
      logic [7:0] e;
      r    = 8'h01;
      base = x;
      e    = 8'd254;
      for (int i = 0; i < 8; i++) begin
         if (e[i]) r = gf_mul(r, base);
         base = gf_mul(base, base);
      end
      return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
               ^ {r[3:0], r[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [7:0] rcon_calc(input int n);
      logic [7:0] v;
      v = 8'h01;
      for (int i = 1; i < 16; i++) begin
         if (i < n) v = gf_x2(v);
      end
      return v;
   endfunction
endpackage

// File: rtl/aes_sbox.sv
`timescale 1ns/1ps
module aes_sbox
   import aes_ks_pkg::*;
(
   input  logic [BYTE_W-1:0] a_i,
   output logic [BYTE_W-1:0] y_o
);
   always_comb y_o = sbox_calc(a_i);
endmodule

// File: rtl/aes_subword.sv
`timescale 1ns/1ps
module aes_subword
   import aes_ks_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int NBYTES = WORD_W / BYTE_W
)(
   input  logic [WORD_W-1:0] w_i,
   output logic [WORD_W-1:0] w_o
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      aes_sbox u_sbox (
         .a_i (w_i[b*BYTE_W +: BYTE_W]),
         .y_o (w_o[b*BYTE_W +: BYTE_W])
      );
   end
endmodule

// File: rtl/aes_ks_step.sv
`timescale 1ns/1ps
module aes_ks_step
   import aes_ks_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NWORDS = 4,
   parameter int RND_W  = 4,
   localparam int KEY_W = WORD_W * NWORDS
)(
   input  logic [KEY_W-1:0] cur_i,
   input  logic [RND_W-1:0] next_rnd_i,
   output logic [KEY_W-1:0] nxt_o
);
   logic [WORD_W-1:0] w   [NWORDS];
   logic [WORD_W-1:0] n   [NWORDS];
   logic [WORD_W-1:0] rot;
   logic [WORD_W-1:0] sub;
   logic [WORD_W-1:0] tmp;
   logic [BYTE_W-1:0] rc;

   for (genvar j = 0; j < NWORDS; j++) begin : g_split
      assign w[j] = cur_i[KEY_W-1-j*WORD_W -: WORD_W];
   end

   assign rot = {w[NWORDS-1][WORD_W-BYTE_W-1:0], w[NWORDS-1][WORD_W-1 -: BYTE_W]};

   aes_subword #(.WORD_W(WORD_W)) u_sub (
      .w_i (rot),
      .w_o (sub)
   );

   always_comb rc = rcon_calc(int'(next_rnd_i));

   assign tmp  = sub ^ {rc, {(WORD_W-BYTE_W){1'b0}}};
   assign n[0] = w[0] ^ tmp;

   for (genvar j = 1; j < NWORDS; j++) begin : g_chain
      assign n[j] = w[j] ^ n[j-1];
   end

   for (genvar j = 0; j < NWORDS; j++) begin : g_join
      assign nxt_o[KEY_W-1-j*WORD_W -: WORD_W] = n[j];
   end
endmodule

// File: rtl/aes_rkey_gen.sv
`timescale 1ns/1ps
module aes_rkey_gen
   import aes_ks_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int NWORDS  = 4,
   parameter int NROUNDS = 10,
   localparam int KEY_W  = WORD_W * NWORDS,
   localparam int RND_W  = $clog2(NROUNDS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [KEY_W-1:0] key_i,
   output logic [KEY_W-1:0] rkey_o,
   output logic [RND_W-1:0] round_o
);
   if (WORD_W % BYTE_W != 0 || WORD_W < 2 * BYTE_W) begin : g_bad_word
      $error("aes_rkey_gen: WORD_W must be a multiple of 8 and at least 16");
   end
   if (NWORDS < 2) begin : g_bad_nwords
      $error("aes_rkey_gen: NWORDS must be at least 2");
   end
   if (NROUNDS < 1 || NROUNDS > 14) begin : g_bad_rounds
      $error("aes_rkey_gen: NROUNDS out of range");
   end

   localparam logic [RND_W-1:0] LAST = RND_W'(NROUNDS);

   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] key_nxt;
   logic [RND_W-1:0] rnd_q;
   logic [RND_W-1:0] rnd_inc;
   logic             step;

   assign rnd_inc = rnd_q + RND_W'(1);
   assign step    = adv_i && (rnd_q != LAST);

   aes_ks_step #(.WORD_W(WORD_W), .NWORDS(NWORDS), .RND_W(RND_W)) u_step (
      .cur_i      (key_q),
      .next_rnd_i (rnd_inc),
      .nxt_o      (key_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         rnd_q <= '0;
      end else if (load_i) begin
         key_q <= key_i;
         rnd_q <= '0;
      end else if (step) begin
         key_q <= key_nxt;
         rnd_q <= rnd_inc;
      end
   end

   assign rkey_o  = key_q;
   assign round_o = rnd_q;
endmodule

// File: rtl/aes_rkey_chk.sv
`timescale 1ns/1ps
module aes_rkey_chk #(
   parameter int KEY_W   = 128,
   parameter int RND_W   = 4,
   parameter int NROUNDS = 10
)(
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic             adv_i,
   input logic [KEY_W-1:0] key_i,
   input logic [KEY_W-1:0] rkey_o,
   input logic [RND_W-1:0] round_o
);
   // R1
   always_comb begin
      if (!rst_n) begin
         reset_state_chk: assert (round_o == '0 && rkey_o == '0);
      end
   end

   // R2
   load_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (round_o == '0 && rkey_o == $past(key_i)));

   // R3
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && round_o != RND_W'(NROUNDS)) |=> (round_o == $past(round_o) + RND_W'(1)));

   // R6
   adv_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && round_o == RND_W'(NROUNDS)) |=> ($stable(round_o) && $stable(rkey_o)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> ($stable(round_o) && $stable(rkey_o)));

   // R10
   round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_o <= RND_W'(NROUNDS));
endmodule

bind aes_rkey_gen aes_rkey_chk #(.KEY_W(KEY_W), .RND_W(RND_W), .NROUNDS(NROUNDS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_i  (load_i),
   .adv_i   (adv_i),
   .key_i   (key_i),
   .rkey_o  (rkey_o),
   .round_o (round_o)
);

// File: tb/aes_rkey_gen_tb.sv
`timescale 1ns/1ps
module aes_rkey_gen_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic         adv_i = 1'b0;
   logic [127:0] key_i = '0;
   logic [127:0] rkey_o;
   logic [3:0]   round_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   logic [127:0] q_key[$];
   logic [3:0]   q_rnd[$];
   int           q_due[$];
   string        q_tag[$];

   logic [127:0] m_key = '0;
   logic [3:0]   m_rnd = '0;

   localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
   localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;

   always #2 clk = ~clk;

   aes_rkey_gen u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_i   (adv_i),
      .key_i   (key_i),
      .rkey_o  (rkey_o),
      .round_o (round_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // reference arithmetic
   function automatic logic [7:0] t_x2(input logic [7:0] a);
      return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
   endfunction

   function automatic logic [7:0] t_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 0;
      logic [7:0] s = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p ^= s;
         s = t_x2(s);
      end
      return p;
   endfunction

   function automatic logic [7:0] t_sbox(input logic [7:0] x);
      logic [7:0] inv = 0;
      logic [7:0] y;
      for (int c = 1; c < 256; c++) begin
         if (x != 0 && t_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
      end
      for (int i = 0; i < 8; i++) begin
         y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      end
      return y ^ 8'h63;
   endfunction

   function automatic logic [7:0] t_rc(input int n);
      case (n)
         1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
         5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
         9: return 8'h1b;  10: return 8'h36;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [127:0] t_next(input logic [127:0] k, input int n);
      logic [31:0] w0 = k[127:96];
      logic [31:0] w1 = k[95:64];
      logic [31:0] w2 = k[63:32];
      logic [31:0] w3 = k[31:0];
      logic [31:0] t;
      logic [31:0] a0, a1, a2, a3;
      t = {t_sbox(w3[23:16]), t_sbox(w3[15:8]), t_sbox(w3[7:0]), t_sbox(w3[31:24])};
      t ^= {t_rc(n), 24'h0};
      a0 = w0 ^ t; a1 = w1 ^ a0; a2 = w2 ^ a1; a3 = w3 ^ a2;
      return {a0, a1, a2, a3};
   endfunction

   // driver: one cycle of stimulus, expected item pushed to the scoreboard
   task automatic step(input bit ld, input bit av, input logic [127:0] k, input string tag,
                       input bit lit, input logic [127:0] lit_key);
      @(posedge clk);
      #1;
      load_i = ld;
      adv_i  = av;
      key_i  = k;
      if (ld) begin
         m_key = k;
         m_rnd = 0;
      end else if (av && m_rnd != 4'd10) begin
         m_key = t_next(m_key, int'(m_rnd) + 1);
         m_rnd = m_rnd + 1;
      end
      q_key.push_back(lit ? lit_key : m_key);
      q_rnd.push_back(m_rnd);
      q_due.push_back(cyc + 1);
      q_tag.push_back(tag);
   endtask

   // monitor
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
         logic [127:0] ek;
         logic [3:0]   er;
         string        tg;
         ek = q_key.pop_front();
         er = q_rnd.pop_front();
         tg = q_tag.pop_front();
         void'(q_due.pop_front());
         total++;
         if (rkey_o !== ek || round_o !== er) begin
            bad++;
            $display("FAIL %s: key=%h round=%0d expected key=%h round=%0d",
                     tg, rkey_o, round_o, ek, er);
         end
      end
   end

   task automatic direct(input string tag, input logic [127:0] ek, input logic [3:0] er);
      total++;
      if (rkey_o !== ek || round_o !== er) begin
         bad++;
         $display("FAIL %s: key=%h round=%0d expected key=%h round=%0d",
                  tag, rkey_o, round_o, ek, er);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      direct("R1 in reset", 128'h0, 4'd0);
      rst_n = 1'b1;
      @(negedge clk);
      direct("R1 after release", 128'h0, 4'd0);

      // key A through all rounds
      step(1, 0, KEY_A, "R2", 0, 0);
      step(0, 1, 0, "R5 round1", 1, 128'hd6aa74fdd2af72fadaa678f1d6ab76fe);
      for (int r = 2; r <= 9; r++) step(0, 1, 0, "R3/R4", 0, 0);
      step(0, 1, 0, "R9 key A", 1, 128'h13111d7fe3944a17f307a78b4d2b30c5);
      step(0, 1, 0, "R6", 0, 0);
      step(0, 1, 0, "R6 again", 0, 0);
      step(0, 0, 0, "R8", 0, 0);

      // key B with idle gaps
      step(1, 0, KEY_B, "R2", 0, 0);
      for (int r = 1; r <= 10; r++) begin
         step(0, 1, 0, (r == 10) ? "R9 key B" : "R4", r == 10,
              128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
         if (r % 3 == 0) step(0, 0, 0, "R8", 0, 0);
      end

      // partial walk then simultaneous strobes
      step(1, 0, KEY_A, "R2", 0, 0);
      step(0, 1, 0, "R3", 0, 0);
      step(0, 1, 0, "R3", 0, 0);
      step(1, 1, KEY_B, "R7", 0, 0);
      step(0, 1, 0, "R4", 0, 0);
      step(0, 0, 0, "R8", 0, 0);

      @(posedge clk);
      #1;
      load_i = 0;
      adv_i  = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule